// File: doc/BRIEF.md
# Calendar Clock Register Bank

This block keeps calendar time in eight byte registers that sit at the top of a 2048-byte address space. Below that window, addresses belong to ordinary memory. The `clk_sel` output tells the surrounding logic which of the two owns the current address.

The internal counters hold seconds, minutes, hours, day of week, date, month and year. Every field is packed BCD, and hours run on a 24-hour scale. A one-second `tick` from an external prescaler advances the counters.

The host never reads the counters directly. It reads a visible copy that follows the counters one cycle behind. Setting the freeze bit in the control byte stops that copy, so a multi-byte time can be read without tearing. The counters keep running while the copy is frozen. Clearing the bit brings the copy up to date on the next clock.

Top module: `rtcb_top`

## Requirements
- R1: Only addresses 7F8h to 7FFh select the bank. For any other address, `clk_sel` is 0, `rdata` is 00h, and a write has no effect on the time or the control byte.
- R2: The register offset within the window selects the byte. Offset 0 is the control byte: bit 6 is the freeze bit, bit 5 is the calibration sign, bits 4:0 are the calibration magnitude, and bit 7 reads 0. Offsets 1 to 7 are seconds (bits 6:0), minutes (6:0), hours (5:0), day of week (2:0), date (5:0), month (4:0) and year (7:0). Bits outside each field are discarded on write and read as 0.
- R3: After reset, the time is 00:00:00, day 1, date 01, month 01, year 00, and the control byte is 00h.
- R4: A write to a time field sets that counter at the write edge. If a tick arrives in the same cycle as a write, the tick is dropped for all fields.
- R5: Seconds and minutes wrap from 59 to 00 and carry into the next field. Hours wrap from 23 to 00 and carry into both day of week and date. BCD digits carry from 9 to the next decade.
- R6: Day of week counts 1 to 7 and then wraps to 1.
- R7: Date wraps to 01 and carries into month after the last day of the month. Months 04, 06, 09 and 11 have 30 days. Month 02 has 29 days when the year is divisible by 4 and 28 otherwise. All other months have 31 days.
- R8: Month wraps from 12 to 01 and carries into year. Year wraps from 99 to 00.
- R9: While the freeze bit is 1, every byte the host reads at offsets 1 to 7 stays constant, and the counters keep advancing on ticks.
- R10: On the first clock edge after the freeze bit is cleared, the visible bytes load the current counter values.
- R11: While unfrozen, the visible bytes equal the counters delayed by one clock. The counters change only on a tick or on a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse, once per second |
| addr | input | ADDR_W | Byte address |
| we | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (combinational from address) |
| clk_sel | output | 1 | Address falls in the clock window |

## Verification
A wrong carry or month-length decision appears at the ports one cycle after the tick that triggers it. It then persists, so every later read of the affected field and all higher fields is off. The bench therefore compares the whole time after each tick around every month end, for leap and common years and the century wrap. A frozen copy that still moves, or an unfreeze that lags, shows up within a single cycle. The bench checks both at exact cycle positions.

// File: rtl/rtcb_pkg.sv
package rtcb_pkg;
  localparam int NFLD = 7;
  localparam int F_SEC = 0, F_MIN = 1, F_HR = 2, F_DOW = 3, F_DATE = 4, F_MON = 5, F_YR = 6;

  typedef logic [7:0] byte_t;
  typedef byte_t [NFLD-1:0] time_t;

  function automatic byte_t fld_mask(int f);
    case (f)
      F_SEC, F_MIN: return 8'h7F;
      F_HR, F_DATE: return 8'h3F;
      F_DOW:        return 8'h07;
      F_MON:        return 8'h1F;
      default:      return 8'hFF;
    endcase
  endfunction

  function automatic byte_t rst_val(int f);
    case (f)
      F_DOW, F_DATE, F_MON: return 8'h01;
      default:              return 8'h00;
    endcase
  endfunction

  function automatic byte_t bcd_inc(byte_t v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // divisible by 4: 10*t + u == 2*t + u (mod 4)
  function automatic logic is_leap(byte_t y);
    logic [4:0] m;
    m = {y[7:4], 1'b0} + {1'b0, y[3:0]};
    return m[1:0] == 2'd0;
  endfunction

  function automatic byte_t month_len(byte_t mo, byte_t yr);
    case (mo)
      8'h02:                      return is_leap(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtcb_decode.sv
module rtcb_decode #(
  parameter int ADDR_W = 11
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [2:0]        ofs
);
  localparam int HI_W = ADDR_W - 3;

  always_comb begin
    hit = (addr[ADDR_W-1:3] == {HI_W{1'b1}});
    ofs = addr[2:0];
  end
endmodule

// File: rtl/rtcb_count.sv
module rtcb_count
  import rtcb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       wr_en,
  input  logic [2:0] wr_fld,
  input  byte_t      wr_data,
  output time_t      cnt_q
);
  time_t cnt_d;
  logic  c_min, c_hr, c_day, c_mon, c_yr;
  logic  upd;

  always_comb begin
    cnt_d = cnt_q;
    c_min = 1'b0;
    c_hr  = 1'b0;
    c_day = 1'b0;
    c_mon = 1'b0;
    c_yr  = 1'b0;
    if (wr_en) begin
      for (int f = 0; f < NFLD; f++)
        if (wr_fld == f[2:0]) cnt_d[f] = wr_data & fld_mask(f);
    end else if (tick) begin
      c_min = (cnt_q[F_SEC] == 8'h59);
      cnt_d[F_SEC] = c_min ? 8'h00 : (bcd_inc(cnt_q[F_SEC]) & fld_mask(F_SEC));
      if (c_min) begin
        c_hr = (cnt_q[F_MIN] == 8'h59);
        cnt_d[F_MIN] = c_hr ? 8'h00 : (bcd_inc(cnt_q[F_MIN]) & fld_mask(F_MIN));
      end
      if (c_hr) begin
        c_day = (cnt_q[F_HR] == 8'h23);
        cnt_d[F_HR] = c_day ? 8'h00 : (bcd_inc(cnt_q[F_HR]) & fld_mask(F_HR));
      end
      if (c_day) begin
        cnt_d[F_DOW] = (cnt_q[F_DOW] >= 8'h07) ? 8'h01 : (cnt_q[F_DOW] + 8'h01);
        c_mon = (cnt_q[F_DATE] == month_len(cnt_q[F_MON], cnt_q[F_YR]));
        cnt_d[F_DATE] = c_mon ? 8'h01 : (bcd_inc(cnt_q[F_DATE]) & fld_mask(F_DATE));
      end
      if (c_mon) begin
        c_yr = (cnt_q[F_MON] == 8'h12);
        cnt_d[F_MON] = c_yr ? 8'h01 : (bcd_inc(cnt_q[F_MON]) & fld_mask(F_MON));
      end
      if (c_yr) begin
        cnt_d[F_YR] = (cnt_q[F_YR] == 8'h99) ? 8'h00 : bcd_inc(cnt_q[F_YR]);
      end
    end
  end

  assign upd = wr_en | tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int f = 0; f < NFLD; f++) cnt_q[f] <= rst_val(f);
    end else if (upd) begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/rtcb_hold.sv
module rtcb_hold
  import rtcb_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load_en,
  input  time_t src,
  output time_t vis_q
);
  for (genvar g = 0; g < NFLD; g++) begin : g_fld
    byte_t r_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       r_q <= rst_val(g);
      else if (load_en) r_q <= src[g];
    end
    assign vis_q[g] = r_q;
  end
endmodule

// File: rtl/rtcb_top.sv
module rtcb_top
  import rtcb_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              clk_sel
);
  localparam int CTRL_W     = 7;
  localparam int FREEZE_BIT = 6;

  logic [1:0]        rst_sync_q;
  logic              rst_n_s;
  logic              hit;
  logic [2:0]        ofs;
  logic [2:0]        fld;
  logic              ctrl_wr, time_wr, freeze;
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  time_t             cnt_q, vis_q;

  // reset asserts at once, leaves in step with clk
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  rtcb_decode #(.ADDR_W(ADDR_W)) u_dec (.addr(addr), .hit(hit), .ofs(ofs));

  always_comb begin
    ctrl_wr = we & hit & (ofs == 3'd0);
    time_wr = we & hit & (ofs != 3'd0);
    fld     = ofs - 3'd1;
    ctrl_d  = ctrl_wr ? wdata[CTRL_W-1:0] : ctrl_q;
    freeze  = ctrl_q[FREEZE_BIT];
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) ctrl_q <= '0;
    else          ctrl_q <= ctrl_d;
  end

  rtcb_count u_cnt (
    .clk(clk), .rst_n(rst_n_s), .tick(tick), .wr_en(time_wr),
    .wr_fld(fld), .wr_data(wdata), .cnt_q(cnt_q)
  );

  rtcb_hold u_hold (
    .clk(clk), .rst_n(rst_n_s), .load_en(!freeze), .src(cnt_q), .vis_q(vis_q)
  );

  always_comb begin
    clk_sel = hit;
    rdata   = 8'h00;
    if (hit) begin
      if (ofs == 3'd0) rdata = {1'b0, ctrl_q};
      else             rdata = vis_q[fld];
    end
  end
endmodule

// File: rtl/rtcb_chk.sv
module rtcb_chk
  import rtcb_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       we,
  input logic       clk_sel,
  input logic [2:0] ofs,
  input logic [7:0] wdata,
  input logic [7:0] rdata,
  input logic       freeze,
  input time_t      cnt,
  input time_t      vis
);
  p_unmapped_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_sel |-> rdata == 8'h00);
  p_unmapped_nowrite_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !clk_sel && !tick) |=> $stable(cnt));
  p_write_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (we && clk_sel && ofs == 3'd1) |=> cnt[F_SEC] == ($past(wdata) & 8'h7F));
  p_sec_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !we && cnt[F_SEC] == 8'h59) |=> cnt[F_SEC] == 8'h00);
  p_dow_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !we && cnt[F_SEC] == 8'h59 && cnt[F_MIN] == 8'h59 &&
     cnt[F_HR] == 8'h23 && cnt[F_DOW] == 8'h07) |=> cnt[F_DOW] == 8'h01);
  p_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> $stable(vis));
  p_track_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !freeze |=> vis == $past(cnt));
  p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !we) |=> $stable(cnt));
endmodule

bind rtcb_top rtcb_chk u_chk (
  .clk(clk), .rst_n(rst_n_s), .tick(tick), .we(we), .clk_sel(clk_sel),
  .ofs(ofs), .wdata(wdata), .rdata(rdata), .freeze(freeze),
  .cnt(cnt_q), .vis(vis_q)
);

// File: tb/rtcb_top_bench.sv
module rtcb_top_bench;
  localparam logic [10:0] BASE = 11'h7F8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, tick, we, clk_sel;
  logic [10:0] addr;
  logic [7:0]  wdata, rdata;
  int checks = 0, errors = 0;
  int s, mi, h, dw, dt, mo, yr;

  rtcb_top #(.ADDR_W(11)) u_rtcb_top (
    .clk(clk), .rst_n(rst_n), .tick(tick), .addr(addr), .we(we),
    .wdata(wdata), .rdata(rdata), .clk_sel(clk_sel)
  );

  function automatic logic [7:0] bcd(int v);
    return 8'(((v / 10) << 4) + (v % 10));
  endfunction

  function automatic int mlen(int m, int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic model_tick();
    s++;
    if (s == 60) begin s = 0; mi++; end
    if (mi == 60) begin mi = 0; h++; end
    if (h == 24) begin
      h = 0;
      dw = (dw == 7) ? 1 : dw + 1;
      dt++;
      if (dt > mlen(mo, yr)) begin
        dt = 1; mo++;
        if (mo == 13) begin mo = 1; yr = (yr + 1) % 100; end
      end
    end
  endtask

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [10:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(logic [10:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #2; d = rdata;
  endtask

  task automatic pulse();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    model_tick();
  endtask

  task automatic set_time(int ns, int nmi, int nh, int ndw, int ndt, int nmo, int nyr);
    s = ns; mi = nmi; h = nh; dw = ndw; dt = ndt; mo = nmo; yr = nyr;
    wr(BASE + 1, bcd(s));  wr(BASE + 2, bcd(mi)); wr(BASE + 3, bcd(h));
    wr(BASE + 4, bcd(dw)); wr(BASE + 5, bcd(dt)); wr(BASE + 6, bcd(mo));
    wr(BASE + 7, bcd(yr));
  endtask

  task automatic check_all(string req);
    logic [7:0] v;
    rd(BASE + 1, v); chk(req, v, bcd(s));
    rd(BASE + 2, v); chk(req, v, bcd(mi));
    rd(BASE + 3, v); chk(req, v, bcd(h));
    rd(BASE + 4, v); chk(req, v, bcd(dw));
    rd(BASE + 5, v); chk(req, v, bcd(dt));
    rd(BASE + 6, v); chk(req, v, bcd(mo));
    rd(BASE + 7, v); chk(req, v, bcd(yr));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic [7:0] snap [7];
    int yrs [7] = '{0, 1, 2, 3, 4, 96, 99};
    rst_n = 1'b0; tick = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R3 reset state
    s = 0; mi = 0; h = 0; dw = 1; dt = 1; mo = 1; yr = 0;
    check_all("R3");
    rd(BASE, v); chk("R3 ctrl", v, 8'h00);

    // R2 field masks and control layout
    wr(BASE + 3, 8'hFF); rd(BASE + 3, v); chk("R2 hour mask", v, 8'h3F);
    wr(BASE + 4, 8'hFF); rd(BASE + 4, v); chk("R2 dow mask", v, 8'h07);
    wr(BASE + 1, 8'hFF); rd(BASE + 1, v); chk("R2 sec mask", v, 8'h7F);
    wr(BASE, 8'hBF);     rd(BASE, v);     chk("R2 ctrl bit7", v, 8'h3F);
    wr(BASE, 8'h00);

    // R1 unmapped addresses
    set_time(56, 34, 12, 3, 15, 6, 21);
    @(negedge clk); addr = BASE - 1; wdata = 8'h33; we = 1'b1; #2;
    chk("R1 sel", {7'd0, clk_sel}, 8'h00);
    chk("R1 rdata", rdata, 8'h00);
    @(negedge clk); addr = 11'h000; #2;
    chk("R1 sel low", {7'd0, clk_sel}, 8'h00);
    @(negedge clk); we = 1'b0;
    check_all("R1 unchanged");
    rd(BASE, v); chk("R1 ctrl", v, 8'h00);

    // R11 one-cycle visible latency
    @(negedge clk); addr = BASE + 2; wdata = 8'h45; we = 1'b1;
    @(negedge clk); we = 1'b0; #2; chk("R11 lag", rdata, 8'h34);
    @(negedge clk); #2; chk("R11 lag", rdata, 8'h45);
    mi = 45;

    // R4 tick dropped on write cycle
    @(negedge clk); addr = BASE + 1; wdata = 8'h10; we = 1'b1; tick = 1'b1;
    @(negedge clk); we = 1'b0; tick = 1'b0;
    s = 10;
    check_all("R4 write wins");

    // R5 run across minute and hour-digit boundaries
    set_time(0, 58, 9, 2, 10, 3, 5);
    for (int i = 0; i < 130; i++) begin
      pulse();
      check_all("R5");
    end

    // R6 day of week wrap
    set_time(59, 59, 23, 7, 10, 3, 5);
    pulse(); check_all("R6");

    // R7 R8 month ends for several years
    foreach (yrs[k]) begin
      for (int m = 1; m <= 12; m++) begin
        set_time(59, 59, 23, 4, mlen(m, yrs[k]) - 1, m, yrs[k]);
        pulse(); check_all("R7 no early wrap");
        set_time(58, 59, 23, 7, mlen(m, yrs[k]), m, yrs[k]);
        for (int t = 0; t < 3; t++) begin
          pulse(); check_all("R8 month end");
        end
      end
    end

    // R9 freeze while counters run
    set_time(50, 59, 23, 7, 31, 12, 99);
    wr(BASE, 8'h40);
    for (int f = 0; f < 7; f++) begin rd(BASE + 1 + f, v); snap[f] = v; end
    for (int t = 0; t < 12; t++) pulse();
    for (int f = 0; f < 7; f++) begin rd(BASE + 1 + f, v); chk("R9 frozen", v, snap[f]); end

    // R10 release: old value on the write cycle, new one a cycle later
    @(negedge clk); addr = BASE; wdata = 8'h00; we = 1'b1;
    @(negedge clk); we = 1'b0; addr = BASE + 1; #2;
    chk("R10 before", rdata, snap[0]);
    @(negedge clk); #2;
    chk("R10 after", rdata, bcd(s));
    check_all("R9 counted");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule